// File: doc/BRIEF.md
# Output Port Decoder with Interrupt Masking

This block sits on an 8-bit-addressed processor bus and watches for output cycles. Each of two output channels has its own port address set by a parameter. A write that names a channel's address is latched into that channel's byte register. The register then holds the value until the processor writes the same channel again.

The low four bits of channel A also serve as interrupt enables for two serial devices. Each device has a receive-ready flag and a transmit-ready flag. A flag can raise a request only while its enable bit holds 1. All enabled requests merge into one active-low interrupt line, which behaves like a wired-OR. The line goes low when any gated request is active and stays high when none is.

Top module: `outport_irq_top`

## Requirements
- R1: A channel latches the data bus on a rising clock edge only when all of the following hold: the low eight address bits equal that channel's port address, the output-cycle status input is 1, and the active-low write strobe is 0.
- R2: A cycle that fails any one of the three qualifiers leaves both channel registers unchanged.
- R3: A write addressed to channel A does not change channel B, and a write addressed to channel B does not change channel A. Both strobes may fire in the same cycle when the two addresses are equal.
- R4: While the synchronous active-low reset is 0 at a clock edge, both channel registers and the interrupt state go to their idle values: the channel bytes become 0x00 and the interrupt line becomes 1.
- R5: The enable bits are fixed by position in channel A's byte:
  - bit 0 gates device 0 receive-ready;
  - bit 1 gates device 0 transmit-ready;
  - bit 2 gates device 1 receive-ready;
  - bit 3 gates device 1 transmit-ready.
  A flag whose enable bit is 0 has no effect on the interrupt line.
- R6: The interrupt line is registered. On each clock edge it takes the NOR of the four gated terms, so it is 0 one cycle after any gated term is 1 and 1 one cycle after all gated terms are 0.
- R7: Bits 7..4 of channel A and all bits of channel B have no effect on the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Address bus; only the low 8 bits are decoded |
| bus_out_cyc | input | 1 | Output-cycle status, high during an output cycle |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_data | input | 8 | Data bus |
| dev0_rx_rdy | input | 1 | Device 0 receive-ready flag |
| dev0_tx_rdy | input | 1 | Device 0 transmit-ready flag |
| dev1_rx_rdy | input | 1 | Device 1 receive-ready flag |
| dev1_tx_rdy | input | 1 | Device 1 transmit-ready flag |
| chan_a_q | output | 8 | Latched byte of channel A |
| chan_b_q | output | 8 | Latched byte of channel B |
| irq_n | output | 1 | Merged interrupt request, active low, registered |

## Verification
The bench builds the block with channel A at port 0x40 and channel B at port 0x41. These neighbouring addresses differ in a single bit, so a decoder that ignored bit 0 would write the wrong channel and be caught. The bench also drives addresses whose high byte is nonzero. This shows that only the low eight bits take part in the match, and that an address differing only in its upper byte still selects the port.

// File: rtl/outport_pkg.sv
// Package: outport_pkg
// Shared widths and the positions of the interrupt enable bits within
// channel A. Assumes an 8-bit data bus and an 8-bit port field.
package outport_pkg;
    localparam int DATA_W  = 8;
    localparam int PORT_W  = 8;
    localparam int N_IRQ   = 4;
    // Enable bit positions in channel A, one per ready flag
    localparam int EN_D0RX = 0;
    localparam int EN_D0TX = 1;
    localparam int EN_D1RX = 2;
    localparam int EN_D1TX = 3;
endpackage

// File: rtl/outport_decode.sv
// Module: outport_decode
// Produces one write strobe per channel from a qualified output cycle.
// Assumes the qualifiers are stable around the sampling clock edge.
module outport_decode #(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8,
    parameter int N_CH   = 2,
    parameter logic [N_CH*PORT_W-1:0] PORT_MAP = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              out_cyc,
    input  logic              wr_n,
    output logic [N_CH-1:0]   wstb
);
    logic qual;

    // Cycle qualifies when status is high and strobe is low
    always_comb qual = out_cyc && !wr_n;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        // Per-channel address match gated by the qualifier
        always_comb wstb[c] = qual && (addr[PORT_W-1:0] == PORT_MAP[c*PORT_W +: PORT_W]);
    end
endmodule

// File: rtl/outport_latch.sv
// Module: outport_latch
// Byte register that loads on its strobe and otherwise holds its value.
// Assumes synchronous active-low reset to zero.
module outport_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Load on strobe, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ld)  q <= d;
    end

    // Holding: without a load the value must not move
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(q));
    // Loading: a strobe captures the bus
    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (q == $past(d)));
endmodule

// File: rtl/outport_irq_merge.sv
// Module: outport_irq_merge
// Gates each ready flag with its enable bit and registers the active-low
// NOR of the gated terms, modelling a wired-OR request line.
// Assumes ready flags are already synchronous to clk.
module outport_irq_merge #(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] rdy,
    input  logic [N_IRQ-1:0] en,
    output logic             irq_n
);
    logic [N_IRQ-1:0] gated;

    // One gated term per source
    always_comb gated = rdy & en;

    // Register the merged request, idle high
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~(|gated);
    end

    // Any active enabled flag pulls the line low next cycle
    assert_irq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rdy & en)) |=> !irq_n);
    // Flags with their enables clear leave the line high
    assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdy & en) == '0) |=> irq_n);
endmodule

// File: rtl/outport_irq_top.sv
// Module: outport_irq_top
// Two output channels decoded from processor output cycles; channel A's
// low nibble enables four serial ready flags into one active-low request.
// Assumes all inputs are synchronous to clk.
module outport_irq_top
    import outport_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [7:0]  PORT_A = 8'h40,
    parameter logic [7:0]  PORT_B = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_out_cyc,
    input  logic              bus_wr_n,
    input  logic [7:0]        bus_data,
    input  logic              dev0_rx_rdy,
    input  logic              dev0_tx_rdy,
    input  logic              dev1_rx_rdy,
    input  logic              dev1_tx_rdy,
    output logic [7:0]        chan_a_q,
    output logic [7:0]        chan_b_q,
    output logic              irq_n
);
    localparam int N_CH = 2;

    logic [N_CH-1:0]   wstb;
    logic [N_IRQ-1:0]  rdy;
    logic [N_IRQ-1:0]  en;

    outport_decode #(
        .ADDR_W (ADDR_W),
        .PORT_W (PORT_W),
        .N_CH   (N_CH),
        .PORT_MAP ({PORT_B, PORT_A})
    ) i_dec (
        .addr    (bus_addr),
        .out_cyc (bus_out_cyc),
        .wr_n    (bus_wr_n),
        .wstb    (wstb)
    );

    outport_latch #(.DATA_W(DATA_W)) i_lat_a (
        .clk (clk), .rst_n (rst_n), .ld (wstb[0]), .d (bus_data), .q (chan_a_q)
    );

    outport_latch #(.DATA_W(DATA_W)) i_lat_b (
        .clk (clk), .rst_n (rst_n), .ld (wstb[1]), .d (bus_data), .q (chan_b_q)
    );

    // Map ready flags and enables onto fixed bit positions
    always_comb begin
        rdy = '0;
        rdy[EN_D0RX] = dev0_rx_rdy;
        rdy[EN_D0TX] = dev0_tx_rdy;
        rdy[EN_D1RX] = dev1_rx_rdy;
        rdy[EN_D1TX] = dev1_tx_rdy;
        en  = chan_a_q[N_IRQ-1:0];
    end

    outport_irq_merge #(.N_IRQ(N_IRQ)) i_irq (
        .clk (clk), .rst_n (rst_n), .rdy (rdy), .en (en), .irq_n (irq_n)
    );

    // Unqualified cycles leave both channels alone
    assert_noqual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_out_cyc || bus_wr_n) |=> ($stable(chan_a_q) && $stable(chan_b_q)));
    // A write to B only leaves A alone (distinct addresses)
    assert_isolate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (PORT_A != PORT_B && bus_addr[7:0] == PORT_B) |=> $stable(chan_a_q));
    // Reset forces idle state
    assert_reset_R4: assert property (@(posedge clk)
        !rst_n |=> (chan_a_q == 8'h00 && chan_b_q == 8'h00 && irq_n));
endmodule

// File: tb/test_outport_irq_top.sv
module test_outport_irq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_out_cyc = 1'b0;
    logic        bus_wr_n = 1'b1;
    logic [7:0]  bus_data = '0;
    logic        d0rx = 0, d0tx = 0, d1rx = 0, d1tx = 0;
    logic [7:0]  chan_a_q, chan_b_q;
    logic        irq_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    outport_irq_top #(.ADDR_W(16), .PORT_A(8'h40), .PORT_B(8'h41)) i_outport_irq_top (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr),
        .bus_out_cyc (bus_out_cyc), .bus_wr_n (bus_wr_n), .bus_data (bus_data),
        .dev0_rx_rdy (d0rx), .dev0_tx_rdy (d0tx),
        .dev1_rx_rdy (d1rx), .dev1_tx_rdy (d1tx),
        .chan_a_q (chan_a_q), .chan_b_q (chan_b_q), .irq_n (irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle spanning a clock edge; sample after it at the falling edge
    task automatic bus_cyc(input logic [15:0] a, input logic oc, input logic wn, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_out_cyc = oc; bus_wr_n = wn; bus_data = d;
        @(negedge clk);
        bus_out_cyc = 1'b0; bus_wr_n = 1'b1;
    endtask

    task automatic set_rdy(input logic [3:0] r);
        @(negedge clk);
        {d1tx, d1rx, d0tx, d0rx} = r;
        @(negedge clk);  // irq register updates at the edge in between
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 chan_a", chan_a_q, 8'h00);
        chk("R4 chan_b", chan_b_q, 8'h00);
        chk("R4 irq_n", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
    endtask

    task automatic t_writes;
        bus_cyc(16'h0040, 1, 0, 8'hA5);
        chk("R1 write A", chan_a_q, 8'hA5);
        chk("R3 B untouched", chan_b_q, 8'h00);
        bus_cyc(16'h3741, 1, 0, 8'h5A);
        chk("R1 write B high byte ignored", chan_b_q, 8'h5A);
        chk("R3 A untouched", chan_a_q, 8'hA5);
        repeat (3) @(negedge clk);
        chk("R1 hold A", chan_a_q, 8'hA5);
    endtask

    task automatic t_unqualified;
        bus_cyc(16'h0040, 0, 0, 8'h11);
        chk("R2 status low", chan_a_q, 8'hA5);
        bus_cyc(16'h0040, 1, 1, 8'h22);
        chk("R2 strobe high", chan_a_q, 8'hA5);
        bus_cyc(16'h0042, 1, 0, 8'h33);
        chk("R2 wrong addr A", chan_a_q, 8'hA5);
        chk("R2 wrong addr B", chan_b_q, 8'h5A);
        bus_cyc(16'h00C0, 1, 0, 8'h44);
        chk("R2 bit7 addr differs", chan_a_q, 8'hA5);
    endtask

    task automatic t_irq;
        bus_cyc(16'h0040, 1, 0, 8'h00);
        set_rdy(4'hF);
        chk("R5 all masked", {7'd0, irq_n}, 8'h01);
        for (int i = 0; i < 4; i++) begin
            bus_cyc(16'h0040, 1, 0, 8'h01 << i);
            set_rdy(4'h1 << i);
            chk($sformatf("R5 bit%0d own flag", i), {7'd0, irq_n}, 8'h00);
            set_rdy(~(4'h1 << i));
            chk($sformatf("R5 bit%0d other flags", i), {7'd0, irq_n}, 8'h01);
        end
        bus_cyc(16'h0040, 1, 0, 8'h0F);
        set_rdy(4'h0);
        chk("R6 none active high", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        {d1tx, d1rx, d0tx, d0rx} = 4'h4;
        chk("R6 not yet registered", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        chk("R6 low after one edge", {7'd0, irq_n}, 8'h00);
        set_rdy(4'h0);
        chk("R6 release high", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_upper_bits;
        bus_cyc(16'h0040, 1, 0, 8'hF0);
        bus_cyc(16'h0041, 1, 0, 8'hFF);
        set_rdy(4'hF);
        chk("R7 upper A and B no effect", {7'd0, irq_n}, 8'h01);
        set_rdy(4'h0);
    endtask

    initial begin
        t_reset();
        t_writes();
        t_unqualified();
        t_irq();
        t_upper_bits();
        t_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule